// File: doc/BRIEF.md
# Pipeline-Wide Stall Recovery Controller

This controller supervises a linear pipeline of speculative stages. Each stage captures its result twice: early on the fast clock into its main register and later into a delayed shadow copy. It raises an error flag when the two disagree. The controller merges all of the per-stage flags. When any flag is seen, it freezes the whole pipeline for exactly one clock cycle. In that cycle, each erring stage copies its shadow value over its main register, and the logic downstream of it recomputes from the corrected value.

A recovery is always a single cycle, whatever the number of stages that failed. If fresh mismatches are flagged during a stall cycle, they are held and served as a second, separate one-cycle recovery that starts on the following cycle. A saturating counter tallies every recovery. Surrounding logic can read it to judge whether the speculative clock is set so fast that recoveries eat up the gain. When that happens, throughput falls below what the safe clock would give.

The controller has two states. RUN is the normal flow state, and STALL is the recovery cycle. The transitions are:

- RUN to STALL on any flag.
- RUN to RUN with no flag.
- STALL to STALL when a new flag arrives during the stall. This is the held-error recovery.
- STALL to RUN with no new flag.

Top module: `recovery_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, stall is 0, restore is all zeros and the recovery count is 0.
- R2: If any bit of err is 1 at a rising clock edge, stall is 1 during the cycle that follows that edge.
- R3: During a stall cycle, restore bit i is 1 exactly when err bit i was 1 at the edge that started that stall. Outside stall cycles, restore is all zeros.
- R4: A recovery lasts exactly one cycle. If err is all zeros at the edge that ends a stall cycle, stall is 0 in the next cycle.
- R5: If err is all zeros at a rising edge, the following cycle has stall at 0, restore at all zeros, and an unchanged recovery count.
- R6: The recovery count rises by exactly one at every edge that starts a stall cycle, and it changes at no other edge.
- R7: The recovery count (16 bits by default) saturates at all ones and stays there on later recoveries.
- R8: An err pattern seen at the edge that ends a stall cycle starts a separate one-cycle recovery in the very next cycle. Its restore carries only the new pattern, and it is counted as a new recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err | input | N_STAGES | Per-stage main/shadow mismatch flags |
| stall | output | 1 | Pipeline-wide freeze, one cycle per recovery |
| restore | output | N_STAGES | Per-stage command to load the shadow value |
| recov_cnt | output | CNT_W | Saturating count of recoveries |

## Verification
Every result is due one cycle after the edge that samples err: stall, restore and the recovery count all come from registers loaded at that same edge. The driver changes err on the falling edge and pushes the expected stall, restore and count for the next rising edge. The monitor pops that item shortly after the rising edge and compares all three outputs. Because of this, each check lines up with exactly one sampled err pattern, including back-to-back recoveries and the long run that drives the count into saturation.

// File: rtl/recovery_ctrl_pkg.sv
package recovery_ctrl_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } rec_state_e;
endpackage

// File: rtl/rec_err_reduce.sv
module rec_err_reduce #(
    parameter int N = 4
) (
    input  logic [N-1:0] err,
    output logic         any_err
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;
    generate
        for (genvar g = 0; g < N; g++) begin : g_or
            assign chain[g+1] = chain[g] | err[g];
        end
    endgenerate
    assign any_err = chain[N];
endmodule

// File: rtl/rec_fsm.sv
module rec_fsm
    import recovery_ctrl_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         any_err,
    input  logic [N-1:0] err,
    output logic         stall,
    output logic [N-1:0] restore,
    output logic         start_rec
);
    rec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = any_err ? ST_STALL : ST_RUN;
            ST_STALL: state_d = any_err ? ST_STALL : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore <= '0;
        end else if (state_d == ST_STALL) begin
            restore <= err;
        end else begin
            restore <= '0;
        end
    end

    assign stall     = (state_q == ST_STALL);
    assign start_rec = (state_d == ST_STALL);
endmodule

// File: rtl/rec_sat_cnt.sv
module rec_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (inc && (cnt != MAX_VAL)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/recovery_ctrl.sv
module recovery_ctrl #(
    parameter int N_STAGES = 4,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] err,
    output logic                stall,
    output logic [N_STAGES-1:0] restore,
    output logic [CNT_W-1:0]    recov_cnt
);
    logic any_err;
    logic start_rec;

    rec_err_reduce #(.N(N_STAGES)) u_reduce (
        .err     (err),
        .any_err (any_err)
    );

    rec_fsm #(.N(N_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_err   (any_err),
        .err       (err),
        .stall     (stall),
        .restore   (restore),
        .start_rec (start_rec)
    );

    rec_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (start_rec),
        .cnt   (recov_cnt)
    );
endmodule

// File: rtl/recovery_ctrl_chk.sv
module recovery_ctrl_chk #(
    parameter int N = 4,
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] err,
    input logic         stall,
    input logic [N-1:0] restore,
    input logic [W-1:0] recov_cnt
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    assert_stall_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0) |=> stall);

    assert_restore_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0) |=> (restore == $past(err)));

    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && err == '0) |=> !stall);

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err == '0) |=> (!stall && restore == '0 && $stable(recov_cnt)));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0 && recov_cnt != MAX_VAL) |=> (recov_cnt == $past(recov_cnt) + 1'b1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_cnt == MAX_VAL) |=> (recov_cnt == MAX_VAL));
endmodule

bind recovery_ctrl recovery_ctrl_chk #(.N(N_STAGES), .W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err       (err),
    .stall     (stall),
    .restore   (restore),
    .recov_cnt (recov_cnt)
);

// File: tb/recovery_ctrl_tb.sv
`timescale 1ns/1ps
module recovery_ctrl_tb;
    localparam int N = 4;
    localparam int W = 16;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct {
        logic         stall;
        logic [N-1:0] restore;
        logic [W-1:0] cnt;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] err = '0;
    logic         stall;
    logic [N-1:0] restore;
    logic [W-1:0] recov_cnt;

    int compared = 0;
    int mismatched = 0;
    exp_t q[$];
    logic [W-1:0] model_cnt = '0;
    bit running = 1'b0;

    always #2.5 clk = ~clk;

    recovery_ctrl #(.N_STAGES(N), .CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .err(err),
        .stall(stall), .restore(restore), .recov_cnt(recov_cnt)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        err = e;
        if (e != '0 && model_cnt != MAXV) model_cnt = model_cnt + 1'b1;
        it.stall   = (e != '0);
        it.restore = e;
        it.cnt     = model_cnt;
        it.tag     = tag;
        q.push_back(it);
    endtask

    // monitor: results are due one edge after err is sampled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check({it.tag, " stall"},   W'(stall),   W'(it.stall));
                check({it.tag, " restore"}, W'(restore), W'(it.restore));
                check({it.tag, " count"},   recov_cnt,   it.cnt);
            end
        end
    end

    initial begin
        #(190000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 stall",   W'(stall),   '0);
        check("R1 restore", W'(restore), '0);
        check("R1 count",   recov_cnt,   '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0000, "R5 idle");
        step(4'b0001, "R2 single stage");
        step(4'b0000, "R4 stall ends");
        step(4'b0000, "R5 idle");
        step(4'b1010, "R3 two stages");
        step(4'b0000, "R4 stall ends");
        step(4'b1111, "R3 all stages");
        step(4'b0000, "R6 count held");
        step(4'b0100, "R2 stage two");
        step(4'b0011, "R8 held new error");
        step(4'b0000, "R4 back to run");
        for (int i = 0; i < 5; i++) step(4'b0000, "R5 quiet run");
        step(4'b1000, "R6 last stage");
        step(4'b0000, "R4 stall ends");
        for (int i = 0; i < 65540; i++) step(4'b0001, "R7 saturation");
        step(4'b0000, "R7 held at max");
        step(4'b0110, "R7 no wrap");
        step(4'b0000, "R5 final idle");
        @(negedge clk);
        @(negedge clk);
        check("R7 final count", recov_cnt, MAXV);
        running = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule